// File: doc/BRIEF.md
# Buck-Boost Dual Duty Mapper and Modulator

This block drives a four-switch noninverting buck-boost power stage from a digital control loop. Once per switching period it takes one signed control sample and turns it into two duty counts, one for the buck leg and one for the boost leg. A period counter then compares those counts against its running value to produce the two gate-enable outputs. The counter runs over a fixed number of clock cycles per period, the full-scale count.

Large negative samples give plain buck operation and large positive samples give plain boost operation. A sample of exactly zero gives pass-through, in which the buck leg is held on and the boost leg held off for the whole period, so neither switches. Nonzero samples inside a narrow band around zero would leave one leg with a duty too close to its rail to switch cleanly. There the block uses a three-interval mapping that keeps both legs toggling and still gives the conversion ratio the sample asks for. A period-kind flag tells the rest of the controller which of the three cases the current period is.

The full-scale count is 960 and the band half-width is 48 counts. A new sample takes effect only at a period boundary, so each period's gate pattern is consistent from start to end.

Top module: `bbm_modulator`

## Requirements
- R1: The control sample is saturated to [-960, 960] before mapping; a sample of 1200 maps as 960 (buck 960, boost 960, kind two-interval) and a sample of -1200 maps as -960 (buck 0, boost 0, kind two-interval).
- R2: For a sample q with q <= -48, the buck duty is 960 + q, the boost duty is 0 and the period kind is two-interval (code 1).
- R3: For a sample q with q >= 48, the buck duty is 960, the boost duty is q and the period kind is two-interval (code 1).
- R4: A sample of 0 gives pass-through: buck duty 960, boost duty 0, period kind code 0, the buck gate high in every cycle of the period and the boost gate low in every cycle.
- R5: For -48 < q < 0, the buck duty is floor(912 * (960 + q) / 960), the boost duty is 48 and the period kind is three-interval (code 2).
- R6: For 0 < q < 48, the buck duty is 912, the boost duty is 48 + floor(912 * q / 960) and the period kind is three-interval (code 2).
- R7: The period counter counts 0 to 959 and then wraps to 0; the period-start output is high exactly in the one cycle per period where the count is 0.
- R8: Duty outputs, period kind and gate pattern change only at a period start; a change of the control sample in the middle of a period has no effect until the next period.
- R9: Each gate is high in the first D cycles of the period and low in the rest, where D is that leg's duty count.
- R10: While reset is held the block is in pass-through (buck duty 960, boost duty 0, kind code 0) with the counter at 0, so period-start is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_in | input | 12 | Signed control sample, two's complement |
| gate_buck | output | 1 | Buck leg gate enable |
| gate_boost | output | 1 | Boost leg gate enable |
| duty_buck | output | 10 | Buck duty count in force for this period |
| duty_boost | output | 10 | Boost duty count in force for this period |
| period_kind | output | 2 | 0 pass-through, 1 two-interval, 2 three-interval |
| period_start | output | 1 | High in the first cycle of each period |

## Verification
The bench drives samples on both sides of each band edge. An inclusive-versus-exclusive mistake would show as a three-interval period at ±48, or as plain buck or boost with one leg pinned at its rail at ±47. Samples of ±1 and 0 check that zero alone gives pass-through, and that the truncated products at the smallest band values come out right; an off-by-one in truncation would give buck 912 instead of 911 at q = -1. Out-of-range samples check the saturation, which would otherwise wrap into a wrong duty. A mid-period sample change checks that the latch waits for the boundary, since a design that latched at once would give a gate pattern with a wrong high count.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    localparam int FULL_SCALE = 960;
    localparam int BAND       = 48;
    localparam int Q_W        = 12;
    localparam int CNT_W      = $clog2(FULL_SCALE);
    localparam int DUTY_W     = $clog2(FULL_SCALE + 1);
    localparam int NUM_LEGS   = 2;
    localparam int LEG_BUCK   = 0;
    localparam int LEG_BOOST  = 1;
    localparam int INNER      = FULL_SCALE - BAND;

    typedef logic signed [Q_W-1:0] ctrl_t;
    typedef logic [DUTY_W-1:0]     duty_t;
    typedef logic [CNT_W-1:0]      count_t;

    typedef enum logic [1:0] {
        PK_PASS  = 2'd0,
        PK_TWO   = 2'd1,
        PK_THREE = 2'd2
    } period_kind_e;

    typedef struct packed {
        duty_t        buck;
        duty_t        boost;
        period_kind_e kind;
    } duty_set_t;

    function automatic int saturate_ctrl(ctrl_t q);
        int v;
        v = int'(q);
        if (v > FULL_SCALE)
            v = FULL_SCALE;
        else if (v < -FULL_SCALE)
            v = -FULL_SCALE;
        return v;
    endfunction

    function automatic period_kind_e classify(int buck, int boost);
        if (boost == 0 && buck == FULL_SCALE)
            return PK_PASS;
        else if (boost > 0 && buck < FULL_SCALE)
            return PK_THREE;
        else
            return PK_TWO;
    endfunction

endpackage

// File: rtl/bbm_duty_mapper.sv
module bbm_duty_mapper
    import bbm_pkg::*;
(
    input  ctrl_t     sample,
    output duty_set_t mapped
);

    int qv;
    int buck_cnt;
    int boost_cnt;

    always_comb begin
        qv = saturate_ctrl(sample);
        if (qv <= -BAND) begin
            buck_cnt  = FULL_SCALE + qv;
            boost_cnt = 0;
        end else if (qv >= BAND) begin
            buck_cnt  = FULL_SCALE;
            boost_cnt = qv;
        end else if (qv < 0) begin
            buck_cnt  = (INNER * (FULL_SCALE + qv)) / FULL_SCALE;
            boost_cnt = BAND;
        end else if (qv > 0) begin
            buck_cnt  = INNER;
            boost_cnt = BAND + (INNER * qv) / FULL_SCALE;
        end else begin
            buck_cnt  = FULL_SCALE;
            boost_cnt = 0;
        end
        mapped.buck  = duty_t'(buck_cnt);
        mapped.boost = duty_t'(boost_cnt);
        mapped.kind  = classify(buck_cnt, boost_cnt);
    end

endmodule

// File: rtl/bbm_period_timer.sv
module bbm_period_timer
    import bbm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output count_t count,
    output logic   at_start,
    output logic   at_end
);

    localparam count_t LAST = count_t'(FULL_SCALE - 1);

    count_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign count    = cnt_q;
    assign at_start = (cnt_q == '0);
    assign at_end   = (cnt_q == LAST);

    // R7: count never leaves the period range
    a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R7: wrap back to zero after the last count
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/bbm_gate_compare.sv
module bbm_gate_compare
    import bbm_pkg::*;
(
    input  count_t                    count,
    input  duty_t [NUM_LEGS-1:0]      duty,
    output logic  [NUM_LEGS-1:0]      gate
);

    duty_t count_ext;
    assign count_ext = duty_t'(count);

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        assign gate[g] = (count_ext < duty[g]);
    end

endmodule

// File: rtl/bbm_modulator.sv
module bbm_modulator
    import bbm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [Q_W-1:0] ctrl_in,
    output logic                 gate_buck,
    output logic                 gate_boost,
    output logic [DUTY_W-1:0]    duty_buck,
    output logic [DUTY_W-1:0]    duty_boost,
    output logic [1:0]           period_kind,
    output logic                 period_start
);

    duty_set_t            mapped;
    duty_set_t            active_q;
    count_t               count;
    logic                 at_start;
    logic                 at_end;
    duty_t [NUM_LEGS-1:0] leg_duty;
    logic  [NUM_LEGS-1:0] leg_gate;

    bbm_duty_mapper u_mapper (
        .sample (ctrl_in),
        .mapped (mapped)
    );

    bbm_period_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .count    (count),
        .at_start (at_start),
        .at_end   (at_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q.buck  <= duty_t'(FULL_SCALE);
            active_q.boost <= '0;
            active_q.kind  <= PK_PASS;
        end else if (at_end) begin
            active_q <= mapped;
        end
    end

    assign leg_duty[LEG_BUCK]  = active_q.buck;
    assign leg_duty[LEG_BOOST] = active_q.boost;

    bbm_gate_compare u_cmp (
        .count (count),
        .duty  (leg_duty),
        .gate  (leg_gate)
    );

    assign gate_buck    = leg_gate[LEG_BUCK];
    assign gate_boost   = leg_gate[LEG_BOOST];
    assign duty_buck    = active_q.buck;
    assign duty_boost   = active_q.boost;
    assign period_kind  = active_q.kind;
    assign period_start = at_start;

    // R8: duty set held for the whole period
    a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
        !at_start |-> ($stable(duty_buck) && $stable(duty_boost) && $stable(period_kind)));

    // R4: pass-through period never switches either leg
    a_r4_pass_quiet: assert property (@(posedge clk) disable iff (rst)
        (period_kind == PK_PASS) |-> (gate_buck && !gate_boost));

    // R5 and R6: three-interval periods keep both legs clear of their rails
    a_r6_three_band: assert property (@(posedge clk) disable iff (rst)
        (period_kind == PK_THREE) |->
            (duty_boost >= duty_t'(BAND) && duty_buck <= duty_t'(INNER)));

    // R1: duties never exceed full scale
    a_r1_duty_range: assert property (@(posedge clk) disable iff (rst)
        duty_buck <= duty_t'(FULL_SCALE) && duty_boost <= duty_t'(FULL_SCALE));

endmodule

// File: tb/bbm_modulator_test.sv
module bbm_modulator_test;

    localparam int CLK_PERIOD = 10;
    localparam int M    = 960;
    localparam int ZB   = 48;
    localparam int WDOG = 200000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic signed [11:0] ctrl_in = '0;
    logic              gate_buck, gate_boost, period_start;
    logic [9:0]        duty_buck, duty_boost;
    logic [1:0]        period_kind;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bbm_modulator uut (
        .clk          (clk),
        .rst          (rst),
        .ctrl_in      (ctrl_in),
        .gate_buck    (gate_buck),
        .gate_boost   (gate_boost),
        .duty_buck    (duty_buck),
        .duty_boost   (duty_boost),
        .period_kind  (period_kind),
        .period_start (period_start)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void expect_map(input int q, output int b, output int s, output int k);
        int v;
        v = q;
        if (v > M) v = M;
        if (v < -M) v = -M;
        if (v == 0) begin
            b = M; s = 0; k = 0;
        end else if (v <= -ZB) begin
            b = M + v; s = 0; k = 1;
        end else if (v >= ZB) begin
            b = M; s = v; k = 1;
        end else if (v < 0) begin
            b = ((M - ZB) * (M + v)) / M; s = ZB; k = 2;
        end else begin
            b = M - ZB; s = ZB + ((M - ZB) * v) / M; k = 2;
        end
    endfunction

    task automatic apply_and_wait(input int q);
        @(negedge clk);
        ctrl_in = 12'(q);
        do @(negedge clk); while (!period_start);
    endtask

    // At a negedge with count 0: observe a full period; optionally change the sample midway
    task automatic observe_period(input string tag, input int exp_b, input int exp_s,
                                  input int exp_k, input bit change, input int new_q);
        int hb, hs, starts, bad_b, bad_s;
        bit low_b, low_s;
        hb = 0; hs = 0; starts = 0; bad_b = 0; bad_s = 0; low_b = 0; low_s = 0;
        check({tag, " R2/R3/R5/R6 buck duty"}, int'(duty_buck), exp_b);
        check({tag, " boost duty"}, int'(duty_boost), exp_s);
        check({tag, " period kind"}, int'(period_kind), exp_k);
        for (int i = 0; i < M; i++) begin
            if (period_start) starts++;
            if (gate_buck) begin hb++; if (low_b) bad_b++; end else low_b = 1;
            if (gate_boost) begin hs++; if (low_s) bad_s++; end else low_s = 1;
            if (change && i == M/2) ctrl_in = 12'(new_q);
            if (i < M - 1) @(negedge clk);
        end
        check({tag, " R9 buck gate high count"}, hb, exp_b);
        check({tag, " R9 boost gate high count"}, hs, exp_s);
        check({tag, " R9 gate contiguity"}, bad_b + bad_s, 0);
        check({tag, " R7 one start per period"}, starts, 1);
        @(negedge clk);
        check({tag, " R7 start after wrap"}, int'(period_start), 1);
    endtask

    task automatic run_sample(input string tag, input int q);
        int b, s, k;
        expect_map(q, b, s, k);
        apply_and_wait(q);
        observe_period(tag, b, s, k, 1'b0, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R10 reset buck duty", int'(duty_buck), M);
        check("R10 reset boost duty", int'(duty_boost), 0);
        check("R10 reset kind", int'(period_kind), 0);
        check("R10 reset start", int'(period_start), 1);
        check("R10 reset gates", {30'd0, gate_buck, gate_boost}, 2);
        rst = 1'b0;
    endtask

    task automatic t_pass;
        run_sample("R4 pass q=0", 0);
    endtask

    task automatic t_buck_outside;
        run_sample("R2 q=-48", -48);
        run_sample("R2 q=-500", -500);
        run_sample("R2 q=-960", -960);
    endtask

    task automatic t_boost_outside;
        run_sample("R3 q=48", 48);
        run_sample("R3 q=500", 500);
        run_sample("R3 q=960", 960);
    endtask

    task automatic t_band_negative;
        run_sample("R5 q=-47", -47);
        run_sample("R5 q=-1", -1);
        run_sample("R5 q=-20", -20);
    endtask

    task automatic t_band_positive;
        run_sample("R6 q=47", 47);
        run_sample("R6 q=1", 1);
        run_sample("R6 q=30", 30);
    endtask

    task automatic t_saturate;
        run_sample("R1 q=1200", 1200);
        run_sample("R1 q=-1200", -1200);
    endtask

    task automatic t_mid_change;
        int b1, s1, k1, b2, s2, k2;
        expect_map(300, b1, s1, k1);
        expect_map(-300, b2, s2, k2);
        apply_and_wait(300);
        observe_period("R8 first period", b1, s1, k1, 1'b1, -300);
        observe_period("R8 next period", b2, s2, k2, 1'b0, 0);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_buck_outside();
        t_boost_outside();
        t_band_negative();
        t_band_positive();
        t_saturate();
        t_mid_change();
        t_pass();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule